// File: doc/BRIEF.md
# SPI Serial Memory Slave Controller

This block is the slave side of a byte-addressed serial memory that answers on a four-wire SPI link. It shifts opcodes, addresses and data in from the serial input, keeps a small status byte with a busy flag and a write-enable latch, and holds the array in on-chip registers. A page write or a status write is collected during the frame. It is committed only when chip select rises after a whole number of bytes of the right length. A timed busy period follows. A pause input lets the host freeze a transfer in mid-byte and pick it up later.

All link pins are sampled on a fast system clock, and edges of the serial clock are found from one registered copy. The serial clock must therefore stay at least two system clocks in each phase. The input pins are assumed to be synchronous to `clk`. The array holds 2^MEM_AW bytes, with MEM_AW between 9 and 16. A write wraps inside a page of PAGE_BYTES bytes, while a sequential read runs on through the whole array.

Top module: `spi_mem_slave`

## Requirements
- R1: After reset, so_oe is low and a status read (opcode 0x05) returns 0x00. Status bit 0 is busy, bit 1 is the write-enable latch, and bits 7:2 are user bits.
- R2: A frame of exactly one byte 0x06 sets the write-enable latch, and a frame of exactly one byte 0x04 clears it.
- R3: A write (0x02) or status write (0x01) sent while the latch is clear changes nothing.
- R4: A read (0x03) with a 16-bit address, MSB first, returns the addressed byte and then the following bytes. Only the low MEM_AW address bits are used.
- R5: The address of a write wraps inside its PAGE_BYTES-aligned page.
- R6: A completed write clears the write-enable latch and holds busy high for BUSY_CYCLES clocks.
- R7: If chip select rises off a byte boundary, or before the command's full length, nothing is written, busy stays low and the latch is kept.
- R8: While busy, every opcode except the status read is ignored with SO undriven, and the status read reports busy.
- R9: An unknown opcode leaves so_oe low for the rest of the frame.
- R10: When hold_n is low while SCK is low, the transfer pauses: so_oe drops, SCK and SI are ignored, and the shift state is kept. Raising hold_n while SCK is low resumes the transfer.
- R11: Clock mode 3 (SCK idle high) gives the same results as mode 0 (SCK idle low).
- R12: A status write of exactly two bytes stores bits 7:2 of its data byte into the user bits.
- R13: Raising chip select ends any pause and tri-states SO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in, sampled on rising SCK |
| hold_n | input | 1 | Pause request, active low |
| so | output | 1 | Serial data out, changes on falling SCK |
| so_oe | output | 1 | Output enable for so |

## Verification
A read or status byte is fetched in the clock after the rising SCK that completes the previous byte. Each of its bits reaches `so` in the clock after the falling SCK that drives it. The bench keeps SCK in each phase for four system clocks and samples SO just before the next rising edge, so every bit has settled by then. Busy begins in the clock after chip select is seen high and lasts BUSY_CYCLES clocks. For that reason the status checks come directly after a write, and again only after a wait longer than that span. Pause checks are made three clocks after hold_n moves, and the pause state takes effect one clock after the move.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  typedef enum logic [7:0] {
    OP_WRSR  = 8'h01,
    OP_WRITE = 8'h02,
    OP_READ  = 8'h03,
    OP_WRDI  = 8'h04,
    OP_RDSR  = 8'h05,
    OP_WREN  = 8'h06
  } opcode_e;

  typedef enum logic [2:0] {
    PH_OPC,
    PH_ADDR,
    PH_WDATA,
    PH_RDATA,
    PH_SDATA,
    PH_WSR,
    PH_TAIL,
    PH_IGNORE
  } phase_e;

  localparam int SR_BUSY = 0;
  localparam int SR_WEL  = 1;

  function automatic logic [7:0] pack_status(logic [5:0] user, logic wel, logic busy);
    return {user, wel, busy};
  endfunction

  function automatic phase_e phase_after_opcode(logic [7:0] op, logic busy);
    if (busy && op != OP_RDSR) return PH_IGNORE;
    case (op)
      OP_READ, OP_WRITE: return PH_ADDR;
      OP_RDSR:           return PH_SDATA;
      OP_WRSR:           return PH_WSR;
      OP_WREN, OP_WRDI:  return PH_TAIL;
      default:           return PH_IGNORE;
    endcase
  endfunction

  function automatic logic [2:0] sat_inc3(logic [2:0] v);
    return (v == 3'd7) ? v : v + 3'd1;
  endfunction

endpackage

// File: rtl/spi_mem_link.sv
module spi_mem_link (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic hold_n,
  output logic rise,
  output logic fall,
  output logic frame_start,
  output logic frame_end,
  output logic paused
);
  logic sck_q, cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
      paused <= 1'b0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      if (cs_n)      paused <= 1'b0;
      else if (!sck) paused <= !hold_n;
    end
  end

  assign rise        = sck & ~sck_q & ~cs_n & ~paused;
  assign fall        = ~sck & sck_q & ~cs_n & ~paused;
  assign frame_start = ~cs_n & cs_q;
  assign frame_end   = cs_n & ~cs_q;

  // R10: the pause state changes only while SCK is low
  a_r10_pause_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$past(cs_n) && paused != $past(paused)) |-> !$past(sck));

  // R13: chip select high cancels a pause
  a_r13_cs_cancels_pause: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !paused);

endmodule

// File: rtl/spi_mem_ctl.sv
module spi_mem_ctl #(
  parameter int BUSY_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wren_go,
  input  logic       wrdi_go,
  input  logic       wrsr_go,
  input  logic       write_go,
  input  logic [5:0] wsr_data,
  output logic       wel,
  output logic       busy,
  output logic [7:0] status_byte
);
  import spi_mem_pkg::*;

  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic [5:0]    user_sr;
  logic          prog_go;

  assign prog_go = write_go | wrsr_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel     <= 1'b0;
      busy    <= 1'b0;
      cnt     <= '0;
      user_sr <= '0;
    end else begin
      if (wren_go)                       wel <= 1'b1;
      else if (wrdi_go || prog_go)       wel <= 1'b0;
      if (wrsr_go) user_sr <= wsr_data;
      if (prog_go) begin
        busy <= 1'b1;
        cnt  <= CW'(BUSY_CYCLES - 1);
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
    end
  end

  assign status_byte = pack_status(user_sr, wel, busy);

  a_r6_wel_drops: assert property (@(posedge clk) disable iff (!rst_n)
    prog_go |=> !wel);

  a_r8_no_go_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !prog_go);

  a_r3_go_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    prog_go |-> wel);

  a_r6_busy_from_go: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(prog_go));

endmodule

// File: rtl/spi_mem_store.sv
module spi_mem_store #(
  parameter int MEM_AW = 10,
  parameter int PW     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_clear,
  input  logic              buf_we,
  input  logic [PW-1:0]     buf_off,
  input  logic [7:0]        buf_data,
  input  logic              commit,
  input  logic [MEM_AW-PW-1:0] page_base,
  input  logic [MEM_AW-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int DEPTH = 1 << MEM_AW;
  localparam int PAGE  = 1 << PW;

  logic [7:0]      mem  [DEPTH];
  logic [7:0]      pbuf [PAGE];
  logic [PAGE-1:0] pvalid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pvalid <= '0;
    else if (buf_clear) pvalid <= '0;
    else if (buf_we)    pvalid[buf_off] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[buf_off] <= buf_data;
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < PAGE; i++) begin
        if (pvalid[i]) mem[{page_base, PW'(i)}] <= pbuf[i];
      end
    end
  end

  assign rd_data = mem[rd_addr];

  // R7: a commit always carries at least one collected byte
  a_r7_commit_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (pvalid != '0));

endmodule

// File: rtl/spi_mem_cmd.sv
module spi_mem_cmd #(
  parameter int MEM_AW = 10,
  parameter int PW     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              si,
  input  logic              rise,
  input  logic              fall,
  input  logic              frame_end,
  input  logic              paused,
  input  logic              busy,
  input  logic              wel,
  input  logic [7:0]        status_byte,
  input  logic [7:0]        rd_data,
  output logic [MEM_AW-1:0] rd_addr,
  output logic              buf_we,
  output logic [PW-1:0]     buf_off,
  output logic [7:0]        buf_data,
  output logic [MEM_AW-PW-1:0] page_base,
  output logic              wren_go,
  output logic              wrdi_go,
  output logic              wrsr_go,
  output logic              write_go,
  output logic [5:0]        wsr_data,
  output logic              so,
  output logic              so_oe
);
  import spi_mem_pkg::*;

  localparam int HI_W = MEM_AW - 8;

  phase_e            phase;
  logic [2:0]        bit_idx, byte_cnt;
  logic [7:0]        sh_in, op, out_sh;
  logic [HI_W-1:0]   addr_hi;
  logic [MEM_AW-1:0] ptr;
  logic [PW-1:0]     woff;
  logic              load_req, out_active, so_q;
  logic [5:0]        wsr_q;
  logic [7:0]        nb;
  logic              byte_done, aligned, out_phase;

  assign nb        = {sh_in[6:0], si};
  assign byte_done = rise && (bit_idx == 3'd7);
  assign aligned   = (bit_idx == 3'd0);
  assign out_phase = (phase == PH_RDATA) || (phase == PH_SDATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_OPC;
      bit_idx    <= '0;
      byte_cnt   <= '0;
      sh_in      <= '0;
      op         <= '0;
      out_sh     <= '0;
      addr_hi    <= '0;
      ptr        <= '0;
      woff       <= '0;
      load_req   <= 1'b0;
      out_active <= 1'b0;
      so_q       <= 1'b0;
      wsr_q      <= '0;
    end else if (cs_n) begin
      phase      <= PH_OPC;
      bit_idx    <= '0;
      byte_cnt   <= '0;
      load_req   <= 1'b0;
      out_active <= 1'b0;
    end else begin
      if (load_req) begin
        load_req <= 1'b0;
        if (phase == PH_SDATA) out_sh <= status_byte;
        else begin
          out_sh <= rd_data;
          ptr    <= ptr + 1'b1;
        end
      end
      if (rise) begin
        sh_in   <= nb;
        bit_idx <= bit_idx + 3'd1;
      end
      if (byte_done) begin
        byte_cnt <= sat_inc3(byte_cnt);
        case (phase)
          PH_OPC: begin
            op    <= nb;
            phase <= phase_after_opcode(nb, busy);
            if (phase_after_opcode(nb, busy) == PH_SDATA) load_req <= 1'b1;
          end
          PH_ADDR: begin
            if (byte_cnt == 3'd1) addr_hi <= nb[HI_W-1:0];
            else begin
              ptr  <= {addr_hi, nb};
              woff <= nb[PW-1:0];
              if (op == OP_READ) begin
                phase    <= PH_RDATA;
                load_req <= 1'b1;
              end else begin
                phase <= PH_WDATA;
              end
            end
          end
          PH_WDATA: woff <= woff + 1'b1;
          PH_RDATA, PH_SDATA: load_req <= 1'b1;
          PH_WSR: if (byte_cnt == 3'd1) wsr_q <= nb[7:2];
          default: ;
        endcase
      end
      if (fall && out_phase && !load_req) begin
        so_q       <= out_sh[7];
        out_sh     <= {out_sh[6:0], 1'b0};
        out_active <= 1'b1;
      end
    end
  end

  assign buf_we    = byte_done && (phase == PH_WDATA);
  assign buf_off   = woff;
  assign buf_data  = nb;
  assign page_base = ptr[MEM_AW-1:PW];
  assign rd_addr   = ptr;
  assign wsr_data  = wsr_q;

  assign wren_go  = frame_end && phase == PH_TAIL && op == OP_WREN && byte_cnt == 3'd1 && aligned;
  assign wrdi_go  = frame_end && phase == PH_TAIL && op == OP_WRDI && byte_cnt == 3'd1 && aligned;
  assign wrsr_go  = frame_end && phase == PH_WSR && byte_cnt == 3'd2 && aligned && wel;
  assign write_go = frame_end && phase == PH_WDATA && byte_cnt >= 3'd4 && aligned && wel;

  assign so    = so_q;
  assign so_oe = out_active & ~paused & ~cs_n;

  // R9: an ignored frame never drives the output
  a_r9_ignore_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IGNORE) |-> !out_active);

  // R10: no serial clock edge is taken while paused
  a_r10_no_edge_paused: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> (!rise && !fall));

  // R7: a write commits only at a byte boundary
  a_r7_go_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    write_go |-> $stable(bit_idx));

endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
  parameter int MEM_AW      = 10,
  parameter int PAGE_BYTES  = 32,
  parameter int BUSY_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  output logic so,
  output logic so_oe
);
  localparam int PW = $clog2(PAGE_BYTES);

  logic rise, fall, frame_start, frame_end, paused;
  logic wren_go, wrdi_go, wrsr_go, write_go;
  logic wel, busy, buf_we;
  logic [7:0] status_byte, rd_data, buf_data;
  logic [5:0] wsr_data;
  logic [PW-1:0] buf_off;
  logic [MEM_AW-PW-1:0] page_base;
  logic [MEM_AW-1:0] rd_addr;

  spi_mem_link u_link (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
    .rise(rise), .fall(fall), .frame_start(frame_start),
    .frame_end(frame_end), .paused(paused)
  );

  spi_mem_cmd #(.MEM_AW(MEM_AW), .PW(PW)) u_cmd (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .si(si), .rise(rise), .fall(fall),
    .frame_end(frame_end), .paused(paused), .busy(busy), .wel(wel),
    .status_byte(status_byte), .rd_data(rd_data), .rd_addr(rd_addr),
    .buf_we(buf_we), .buf_off(buf_off), .buf_data(buf_data),
    .page_base(page_base), .wren_go(wren_go), .wrdi_go(wrdi_go),
    .wrsr_go(wrsr_go), .write_go(write_go), .wsr_data(wsr_data),
    .so(so), .so_oe(so_oe)
  );

  spi_mem_ctl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wren_go(wren_go), .wrdi_go(wrdi_go),
    .wrsr_go(wrsr_go), .write_go(write_go), .wsr_data(wsr_data),
    .wel(wel), .busy(busy), .status_byte(status_byte)
  );

  spi_mem_store #(.MEM_AW(MEM_AW), .PW(PW)) u_store (
    .clk(clk), .rst_n(rst_n), .buf_clear(frame_start), .buf_we(buf_we),
    .buf_off(buf_off), .buf_data(buf_data), .commit(write_go),
    .page_base(page_base), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // R13: SO is released whenever chip select is high
  a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> !so_oe);

endmodule

// File: tb/spi_mem_slave_test.sv
module spi_mem_slave_test;
  localparam int BUSY = 400;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic so, so_oe;

  int checks = 0, errors = 0;
  logic done = 1'b0;
  logic oe_seen;
  logic [7:0] rx_sh, v;
  logic [7:0] d4 [4];
  logic [7:0] r4 [4];

  always #2.5 clk = ~clk;

  spi_mem_slave #(.MEM_AW(10), .PAGE_BYTES(32), .BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .so(so), .so_oe(so_oe)
  );

  // {address[15:0], data[7:0]}
  localparam logic [23:0] VEC [6] = '{
    24'h0000_5A, 24'h0011_C3, 24'h01FF_7E,
    24'h0200_81, 24'h03FF_FF, 24'h8123_3C
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic open_f(input logic m3);
    sck = m3; tick(1); cs_n = 1'b0; tick(2); oe_seen = 1'b0;
  endtask

  task automatic close_f(input logic m3);
    if (!m3) begin sck = 1'b0; tick(HALF); end
    cs_n = 1'b1; tick(6);
  endtask

  task automatic bit_io(input logic b);
    sck = 1'b0; si = b; tick(HALF);
    rx_sh = {rx_sh[6:0], so};
    if (so_oe) oe_seen = 1'b1;
    sck = 1'b1; tick(HALF);
  endtask

  task automatic byte_io(input logic [7:0] tx);
    for (int i = 7; i >= 0; i--) bit_io(tx[i]);
  endtask

  task automatic cmd1(input logic m3, input logic [7:0] opc);
    open_f(m3); byte_io(opc); close_f(m3);
  endtask

  task automatic rdsr(input logic m3, output logic [7:0] s);
    open_f(m3); byte_io(8'h05); byte_io(8'h00); s = rx_sh; close_f(m3);
  endtask

  task automatic write_n(input logic m3, input logic [15:0] a, input int n);
    open_f(m3); byte_io(8'h02); byte_io(a[15:8]); byte_io(a[7:0]);
    for (int i = 0; i < n; i++) byte_io(d4[i]);
    close_f(m3);
  endtask

  task automatic read_n(input logic m3, input logic [15:0] a, input int n);
    open_f(m3); byte_io(8'h03); byte_io(a[15:8]); byte_io(a[7:0]);
    for (int i = 0; i < n; i++) begin byte_io(8'h00); r4[i] = rx_sh; end
    close_f(m3);
  endtask

  task automatic pause_here(input logic junk);
    sck = 1'b0; tick(HALF);
    hold_n = 1'b0; tick(3);
    chk("R10 so_oe while paused", {7'd0, so_oe}, 8'h00);
    for (int k = 0; k < 3; k++) begin
      si = junk; sck = 1'b1; tick(HALF); si = ~junk; sck = 1'b0; tick(HALF);
    end
    hold_n = 1'b1; tick(3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(5); rst_n = 1'b1; tick(3);
    // R1 reset state
    chk("R1 so_oe after reset", {7'd0, so_oe}, 8'h00);
    rdsr(1'b0, v); chk("R1 status after reset", v, 8'h00);

    // R4 table of write/read vectors
    foreach (VEC[i]) begin
      cmd1(1'b0, 8'h06);
      d4[0] = VEC[i][7:0];
      write_n(1'b0, VEC[i][23:8], 1);
      tick(BUSY + 20);
      read_n(1'b0, VEC[i][23:8], 1);
      chk("R4 table read", r4[0], VEC[i][7:0]);
    end
    read_n(1'b0, 16'h0123, 1); chk("R4 high address bits ignored", r4[0], 8'h3C);
    read_n(1'b0, 16'h03FF, 2); chk("R4 read wraps array", r4[1], 8'h5A);

    // R3 write without latch
    d4[0] = 8'hEE; write_n(1'b0, 16'h0011, 1); tick(20);
    rdsr(1'b0, v); chk("R3 no busy without latch", v, 8'h00);
    read_n(1'b0, 16'h0011, 1); chk("R3 data kept", r4[0], 8'hC3);

    // R2 latch set and clear
    cmd1(1'b0, 8'h06); rdsr(1'b0, v); chk("R2 latch set", v, 8'h02);
    cmd1(1'b0, 8'h04); rdsr(1'b0, v); chk("R2 latch cleared", v, 8'h00);

    // R5 page wrap: offset 30 of page 0x20
    cmd1(1'b0, 8'h06);
    d4[0] = 8'h11; d4[1] = 8'h22; d4[2] = 8'h33;
    write_n(1'b0, 16'h003E, 3);
    // R6 busy right after write, latch cleared
    rdsr(1'b0, v); chk("R6 busy and latch cleared", v, 8'h01);
    // R8 read while busy stays silent
    read_n(1'b0, 16'h0000, 1); chk("R8 SO undriven while busy", {7'd0, oe_seen}, 8'h00);
    tick(BUSY + 20);
    rdsr(1'b0, v); chk("R6 busy ended", v, 8'h00);
    read_n(1'b0, 16'h0020, 1); chk("R5 wrapped byte", r4[0], 8'h33);
    read_n(1'b0, 16'h003E, 2); chk("R5 first byte", r4[0], 8'h11);
    chk("R4 sequential byte", r4[1], 8'h22);

    // R7 abort on odd bit count
    cmd1(1'b0, 8'h06);
    open_f(1'b0); byte_io(8'h02); byte_io(8'h00); byte_io(8'h00); byte_io(8'h99);
    bit_io(1'b1); bit_io(1'b0); bit_io(1'b1); close_f(1'b0);
    rdsr(1'b0, v); chk("R7 no busy and latch kept", v, 8'h02);
    read_n(1'b0, 16'h0000, 1); chk("R7 data kept", r4[0], 8'h5A);
    // R7 write with address only
    open_f(1'b0); byte_io(8'h02); byte_io(8'h00); byte_io(8'h00); close_f(1'b0);
    rdsr(1'b0, v); chk("R7 short write aborted", v, 8'h02);

    // R9 unknown opcode
    open_f(1'b0); byte_io(8'hAB); byte_io(8'h00); byte_io(8'h00); close_f(1'b0);
    chk("R9 SO undriven", {7'd0, oe_seen}, 8'h00);

    // R10 pause during a write data byte: junk SI must not land
    open_f(1'b0); byte_io(8'h02); byte_io(8'h00); byte_io(8'h40);
    for (int i = 7; i >= 4; i--) bit_io(d4[0][i] ^ 1'b0 ? 1'b1 : 1'b0);
    pause_here(1'b0);
    for (int i = 3; i >= 0; i--) bit_io(1'b1);
    close_f(1'b0);
    tick(BUSY + 20);
    read_n(1'b0, 16'h0040, 1); chk("R10 written byte intact", r4[0], {d4[0][7:4], 4'hF});

    // R10 pause during a read data byte
    open_f(1'b0); byte_io(8'h03); byte_io(8'h00); byte_io(8'h11);
    for (int i = 0; i < 4; i++) bit_io(1'b0);
    pause_here(1'b1);
    chk("R10 so_oe after resume", {7'd0, so_oe}, 8'h01);
    for (int i = 0; i < 4; i++) bit_io(1'b0);
    close_f(1'b0);
    chk("R10 read resumed", rx_sh, 8'hC3);

    // R11 mode 3
    cmd1(1'b1, 8'h06); rdsr(1'b1, v); chk("R11 mode3 status", v, 8'h02);
    d4[0] = 8'hA5; write_n(1'b1, 16'h0155, 1); tick(BUSY + 20);
    read_n(1'b1, 16'h0155, 1); chk("R11 mode3 read", r4[0], 8'hA5);

    // R13 chip select during pause
    open_f(1'b0); byte_io(8'h05); bit_io(1'b0);
    sck = 1'b0; tick(HALF); hold_n = 1'b0; tick(3);
    cs_n = 1'b1; tick(3);
    chk("R13 SO released", {7'd0, so_oe}, 8'h00);
    hold_n = 1'b1; tick(4);
    rdsr(1'b0, v); chk("R13 next frame normal", v, 8'h00);

    // R12 status write
    open_f(1'b0); byte_io(8'h01); byte_io(8'hAB); close_f(1'b0); tick(20);
    rdsr(1'b0, v); chk("R12 needs latch", v, 8'h00);
    cmd1(1'b0, 8'h06);
    open_f(1'b0); byte_io(8'h01); byte_io(8'hAB); close_f(1'b0);
    tick(BUSY + 20);
    rdsr(1'b0, v); chk("R12 user bits stored", v, 8'hA8);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule